// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block works out the next program counter and the cycle cost of one control-transfer instruction in a processor whose program counter is 22 bits wide. The decoder gives it the operation, the current PC and the operands it may need: a signed relative offset, an absolute target, a 16-bit pointer register, an extension register for the upper PC bits, the status vector with a bit selector, the condition of a skip and a flag saying whether the next instruction is two words long.

One operation is accepted on every clock where `issue` is high. The result is registered and appears on `next_pc` and `cycles` in the following cycle. It holds until the next issue. Return-address storage for calls is handled elsewhere; here a call differs from a jump only in its cycle count.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first issue, `next_pc` is 0 and `cycles` is 0. Outputs change only in the cycle after a clock edge at which `issue` was 1. When `issue` is 0, the outputs keep their values whatever the other inputs do.
- R2: Operation codes on `op`: 0 step, 1 relative jump, 2 relative call, 3 absolute jump, 4 absolute call, 5 indirect jump, 6 indirect call, 7 extended-indirect jump, 8 extended-indirect call, 9 branch if selected flag set, 10 branch if selected flag clear, 11 signed greater-or-equal, 12 signed less-than, 13 unsigned same-or-higher, 14 unsigned lower, 15 skip. A step gives PC+1 in 1 cycle.
- R3: A relative jump or relative call gives PC + sign-extended 12-bit `rel_off` + 1, wrapping modulo 2^22. The jump costs 2 cycles and the call 3.
- R4: An absolute jump or absolute call gives `abs_tgt`. The jump costs 3 cycles and the call 4.
- R5: An indirect jump or indirect call gives `ptr` in bits 15:0 and zero in bits 21:16. The jump costs 2 cycles and the call 3.
- R6: An extended-indirect jump or call gives `ptr` in bits 15:0 and `ext` in bits 21:16. The jump costs 2 cycles and the call 4.
- R7: A flag branch tests `status[flag_sel]`: op 9 is taken when that bit is 1, op 10 when it is 0. A taken branch gives PC + sign-extended `rel_off[6:0]` + 1 in 2 cycles. A branch that is not taken gives PC+1 in 1 cycle.
- R8: In the status vector, bit 2 is N and bit 3 is V. The signed greater-or-equal branch is taken when N XOR V is 0, and the signed less-than branch when it is 1. Targets and cycle counts follow R7.
- R9: Bit 0 of the status vector is C. The same-or-higher branch is taken when C is 0, and the lower branch when C is 1. Targets and cycle counts follow R7.
- R10: A skip with `skip_cond` low gives PC+1 in 1 cycle. With `skip_cond` high it gives PC+3 in 3 cycles when `next_two_word` is 1, and PC+2 in 2 cycles when it is 0.
- R11: Conditional branches use only `rel_off[6:0]`. Bits 11:7 of `rel_off` have no effect on a branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Accept the operation on this edge |
| op | input | 4 | Operation code (R2) |
| cur_pc | input | 22 | PC of the current instruction |
| rel_off | input | 12 | Signed relative offset |
| abs_tgt | input | 22 | Absolute target |
| ptr | input | 16 | Pointer register |
| ext | input | 6 | Extension for PC bits 21:16 |
| status | input | 8 | Status vector (C bit 0, N bit 2, V bit 3) |
| flag_sel | input | 3 | Status bit tested by ops 9 and 10 |
| skip_cond | input | 1 | Skip condition holds |
| next_two_word | input | 1 | Following instruction is two words long |
| next_pc | output | 22 | Registered next PC |
| cycles | output | 3 | Registered cycle count |

## Verification
Every operation code is crossed with PCs at zero, at the top of the address space and in between. This shows that relative additions wrap modulo 2^22 and that the absolute and pointer forms ignore the PC. The offsets include the extremes of both the 12-bit and the 7-bit ranges, and values whose low seven bits have the opposite sign to the full field. These separate the long and short sign extension. A stride through the status vector, with the bit selector varying, makes every branch condition both taken and not taken. The same stride also sets skip conditions and next-instruction lengths, so all three skip distances occur. Cycles with `issue` low and changed inputs show that the outputs hold.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    OP_STEP   = 4'd0,
    OP_RJMP   = 4'd1,
    OP_RCALL  = 4'd2,
    OP_AJMP   = 4'd3,
    OP_ACALL  = 4'd4,
    OP_IJMP   = 4'd5,
    OP_ICALL  = 4'd6,
    OP_XJMP   = 4'd7,
    OP_XCALL  = 4'd8,
    OP_BFSET  = 4'd9,
    OP_BFCLR  = 4'd10,
    OP_BGE    = 4'd11,
    OP_BLT    = 4'd12,
    OP_BSH    = 4'd13,
    OP_BLO    = 4'd14,
    OP_SKIP   = 4'd15
  } npc_op_e;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 3;
  localparam int unsigned CYC_W  = 3;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int unsigned SR_W  = 8,
  localparam int unsigned SEL_W = $clog2(SR_W)
) (
  input  npc_op_e           op,
  input  logic [SR_W-1:0]   status,
  input  logic [SEL_W-1:0]  flag_sel,
  input  logic              skip_cond,
  output logic              taken
);

  logic sel_bit, n_xor_v;

  always_comb begin
    sel_bit = status[flag_sel];
    n_xor_v = status[FLAG_N] ^ status[FLAG_V];
    unique case (op)
      OP_BFSET: taken = sel_bit;
      OP_BFCLR: taken = ~sel_bit;
      OP_BGE:   taken = ~n_xor_v;
      OP_BLT:   taken = n_xor_v;
      OP_BSH:   taken = ~status[FLAG_C];
      OP_BLO:   taken = status[FLAG_C];
      OP_SKIP:  taken = skip_cond;
      default:  taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned PC_W  = 22,
  parameter int unsigned PTR_W = 16,
  parameter int unsigned REL_W = 12,
  parameter int unsigned BR_W  = 7,
  localparam int unsigned EXT_W = PC_W - PTR_W
) (
  input  npc_op_e           op,
  input  logic [PC_W-1:0]   pc,
  input  logic [REL_W-1:0]  rel_off,
  input  logic [PC_W-1:0]   abs_tgt,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [EXT_W-1:0]  ext,
  input  logic              taken,
  input  logic              two_word,
  output logic [PC_W-1:0]   npc,
  output logic [CYC_W-1:0]  cyc
);

  logic [PC_W-1:0] rel_long, rel_short, seq_pc, jmp_pc, br_pc, skip_pc;

  always_comb begin
    rel_long  = {{(PC_W-REL_W){rel_off[REL_W-1]}}, rel_off};
    rel_short = {{(PC_W-BR_W){rel_off[BR_W-1]}}, rel_off[BR_W-1:0]};
    seq_pc    = pc + PC_W'(1);
    jmp_pc    = seq_pc + rel_long;
    br_pc     = seq_pc + rel_short;
    skip_pc   = pc + (two_word ? PC_W'(3) : PC_W'(2));
  end

  always_comb begin
    npc = seq_pc;
    cyc = CYC_W'(1);
    unique case (op)
      OP_STEP:  begin npc = seq_pc;  cyc = CYC_W'(1); end
      OP_RJMP:  begin npc = jmp_pc;  cyc = CYC_W'(2); end
      OP_RCALL: begin npc = jmp_pc;  cyc = CYC_W'(3); end
      OP_AJMP:  begin npc = abs_tgt; cyc = CYC_W'(3); end
      OP_ACALL: begin npc = abs_tgt; cyc = CYC_W'(4); end
      OP_IJMP:  begin npc = {{EXT_W{1'b0}}, ptr}; cyc = CYC_W'(2); end
      OP_ICALL: begin npc = {{EXT_W{1'b0}}, ptr}; cyc = CYC_W'(3); end
      OP_XJMP:  begin npc = {ext, ptr}; cyc = CYC_W'(2); end
      OP_XCALL: begin npc = {ext, ptr}; cyc = CYC_W'(4); end
      OP_SKIP: begin
        if (taken) begin
          npc = skip_pc;
          cyc = two_word ? CYC_W'(3) : CYC_W'(2);
        end
      end
      default: begin
        if (taken) begin
          npc = br_pc;
          cyc = CYC_W'(2);
        end
      end
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned PC_W  = 22,
  parameter int unsigned PTR_W = 16,
  parameter int unsigned REL_W = 12,
  parameter int unsigned BR_W  = 7,
  parameter int unsigned SR_W  = 8,
  localparam int unsigned EXT_W = PC_W - PTR_W,
  localparam int unsigned SEL_W = $clog2(SR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [3:0]        op,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [REL_W-1:0]  rel_off,
  input  logic [PC_W-1:0]   abs_tgt,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [EXT_W-1:0]  ext,
  input  logic [SR_W-1:0]   status,
  input  logic [SEL_W-1:0]  flag_sel,
  input  logic              skip_cond,
  input  logic              next_two_word,
  output logic [PC_W-1:0]   next_pc,
  output logic [CYC_W-1:0]  cycles
);

  logic              rst_n_s;
  npc_op_e           op_e;
  logic              taken;
  logic [PC_W-1:0]   npc_d, npc_q;
  logic [CYC_W-1:0]  cyc_d, cyc_q;

  assign op_e = npc_op_e'(op);

  npc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  npc_cond #(.SR_W(SR_W)) u_cond (
    .op        (op_e),
    .status    (status),
    .flag_sel  (flag_sel),
    .skip_cond (skip_cond),
    .taken     (taken)
  );

  npc_select #(
    .PC_W(PC_W), .PTR_W(PTR_W), .REL_W(REL_W), .BR_W(BR_W)
  ) u_sel (
    .op       (op_e),
    .pc       (cur_pc),
    .rel_off  (rel_off),
    .abs_tgt  (abs_tgt),
    .ptr      (ptr),
    .ext      (ext),
    .taken    (taken),
    .two_word (next_two_word),
    .npc      (npc_d),
    .cyc      (cyc_d)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      npc_q <= '0;
      cyc_q <= '0;
    end else if (issue) begin
      npc_q <= npc_d;
      cyc_q <= cyc_d;
    end
  end

  assign next_pc = npc_q;
  assign cycles  = cyc_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !issue |=> $stable(next_pc) && $stable(cycles));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue && op == 4'd0 |=> next_pc == $past(cur_pc) + PC_W'(1) && cycles == CYC_W'(1));

  assert_indirect_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue && (op == 4'd5 || op == 4'd6) |=> next_pc == {{EXT_W{1'b0}}, $past(ptr)});

  assert_branch_cyc_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue && op >= 4'd9 && op <= 4'd14 |=> cycles == CYC_W'(1) || cycles == CYC_W'(2));

  assert_skip_none_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue && op == 4'd15 && !skip_cond |=> next_pc == $past(cur_pc) + PC_W'(1) && cycles == CYC_W'(1));

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  op = '0;
  logic [21:0] cur_pc = '0;
  logic [11:0] rel_off = '0;
  logic [21:0] abs_tgt = '0;
  logic [15:0] ptr = '0;
  logic [5:0]  ext = '0;
  logic [7:0]  status = '0;
  logic [2:0]  flag_sel = '0;
  logic        skip_cond = 1'b0;
  logic        next_two_word = 1'b0;
  logic [21:0] next_pc;
  logic [2:0]  cycles;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .cur_pc(cur_pc),
    .rel_off(rel_off), .abs_tgt(abs_tgt), .ptr(ptr), .ext(ext),
    .status(status), .flag_sel(flag_sel), .skip_cond(skip_cond),
    .next_two_word(next_two_word), .next_pc(next_pc), .cycles(cycles)
  );

  function automatic string req_of(input int o);
    if (o == 0) return "R2";
    if (o <= 2) return "R3";
    if (o <= 4) return "R4";
    if (o <= 6) return "R5";
    if (o <= 8) return "R6";
    if (o <= 10) return "R7/R11";
    if (o <= 12) return "R8/R11";
    if (o <= 14) return "R9/R11";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [21:0] e_pc, input int e_cyc);
    n_vec++;
    if (next_pc !== e_pc || int'(cycles) != e_cyc) begin
      n_bad++;
      $display("FAIL %s: next_pc=%h cycles=%0d expected next_pc=%h cycles=%0d",
               req, next_pc, cycles, e_pc, e_cyc);
    end
  endtask

  task automatic expect_of(output logic [21:0] e_pc, output int e_cyc);
    int o;
    int br_off;
    int j_off;
    bit tk;
    o = int'(op);
    j_off  = rel_off[11] ? int'(rel_off) - 4096 : int'(rel_off);
    br_off = rel_off[6] ? int'(rel_off[6:0]) - 128 : int'(rel_off[6:0]);
    e_pc = cur_pc + 22'd1;
    e_cyc = 1;
    tk = 1'b0;
    case (o)
      1: begin e_pc = cur_pc + 22'(j_off + 1); e_cyc = 2; end
      2: begin e_pc = cur_pc + 22'(j_off + 1); e_cyc = 3; end
      3: begin e_pc = abs_tgt; e_cyc = 3; end
      4: begin e_pc = abs_tgt; e_cyc = 4; end
      5: begin e_pc = {6'd0, ptr}; e_cyc = 2; end
      6: begin e_pc = {6'd0, ptr}; e_cyc = 3; end
      7: begin e_pc = {ext, ptr}; e_cyc = 2; end
      8: begin e_pc = {ext, ptr}; e_cyc = 4; end
      15: if (skip_cond) begin
            e_pc = cur_pc + (next_two_word ? 22'd3 : 22'd2);
            e_cyc = next_two_word ? 3 : 2;
          end
      default: ;
    endcase
    if (o >= 9 && o <= 14) begin
      case (o)
        9:  tk = status[flag_sel] == 1'b1;
        10: tk = status[flag_sel] == 1'b0;
        11: tk = (status[2] ^ status[3]) == 1'b0;
        12: tk = (status[2] ^ status[3]) == 1'b1;
        13: tk = status[0] == 1'b0;
        default: tk = status[0] == 1'b1;
      endcase
      if (tk) begin e_pc = cur_pc + 22'(br_off + 1); e_cyc = 2; end
    end
  endtask

  logic [21:0] pcs [5] = '{22'h000000, 22'h3FFFFF, 22'h012345, 22'h200000, 22'h000040};
  logic [11:0] offs [8] = '{12'h000, 12'h001, 12'hFFF, 12'h7FF, 12'h800, 12'h03F, 12'h040, 12'h0C5};

  initial begin : watchdog
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    logic [21:0] e_pc;
    int e_cyc;
    logic [21:0] held_pc;
    logic [2:0]  held_cyc;
    repeat (3) @(negedge clk);
    // R1: reset values while reset asserted
    check("R1", 22'd0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: no issue yet after release
    check("R1", 22'd0, 0);

    for (int o = 0; o < 16; o++) begin
      for (int pi = 0; pi < 5; pi++) begin
        for (int oi = 0; oi < 8; oi++) begin
          for (int si = 0; si < 16; si++) begin
            op = 4'(o);
            cur_pc = pcs[pi];
            rel_off = offs[oi];
            abs_tgt = 22'h2A5A5A ^ 22'(pi * 4099 + oi * 77);
            ptr = 16'hA5C3 ^ 16'(oi * 1031 + si * 7);
            ext = 6'(pi * 13 + si);
            status = 8'(si * 17) ^ 8'(oi);
            flag_sel = 3'(si + oi);
            skip_cond = si[0];
            next_two_word = si[1];
            issue = 1'b1;
            @(posedge clk);
            @(negedge clk);
            expect_of(e_pc, e_cyc);
            check(req_of(o), e_pc, e_cyc);
          end
        end
      end
      // R1: outputs hold when issue is low, whatever the inputs do
      held_pc = next_pc;
      held_cyc = cycles;
      issue = 1'b0;
      op = 4'(15 - o);
      cur_pc = ~cur_pc;
      rel_off = ~rel_off;
      ptr = ~ptr;
      skip_cond = ~skip_cond;
      repeat (2) @(negedge clk);
      check("R1", held_pc, int'(held_cyc));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule